// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave end of a two-wire serial memory. A system clock samples the open-drain clock and data lines. The block finds START and STOP conditions, decodes the device select byte, and answers with an acknowledge when the select matches. It then serves byte writes and reads against an internal byte array. The array is written so that it maps onto block RAM. The data line is driven only by pulling it low. A board-level pull-up, or the bench, supplies the high level.

A write takes three bytes: select, byte address, data. The byte is held until STOP, which commits it to the array and starts a timed programming window. The bus is ignored for that whole window. While the write-lock input is high, the select and address bytes are still acknowledged, but the data byte gets no acknowledge and is dropped. Reads return bytes from an address counter. The counter steps after every byte sent and wraps at the top of the array. This gives random reads (a short write that only sets the address, then a repeated START), current-address reads and sequential reads. A power-on hold input keeps the slave silent.

Top module: `twi_mem_slave`

## Requirements
- R1: After `rst`, `sda_low` is 0 and `busy` is 0. While `por_hold` is 1, a select byte that would otherwise match gets no acknowledge.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A select byte is sent MSB first and matches when its bits 7..4 are 1010 and the bits above the block bits in 3..1 are 0. Bit 0 set to 1 means read and 0 means write. A matching select is acknowledged by SDA low during the 9th clock.
- R3: A select byte that does not match gets no acknowledge. The slave then ignores every clock until the next START.
- R4: In write mode the byte after the select is the byte address, and it is acknowledged. The data byte after it is acknowledged when `wr_lock` is 0, and it can be read back once the STOP that ends the command has been given.
- R5: With `wr_lock` at 1, the select and address bytes are acknowledged, the data byte is not, memory keeps its old value, and `busy` stays 0 after STOP.
- R6: A STOP that ends an accepted write raises `busy` for exactly WR_CYCLES clocks. While `busy` is 1, a select byte gets no acknowledge.
- R7: A random read works as follows: a write select and address, no data, a repeated START, then a read select. It returns the byte stored at that address.
- R8: After each byte sent, the address counter increments and wraps from the top of the array to 0. A read select with no address byte reads from the counter (current-address read).
- R9: Only one data byte is taken per write command. A second data byte gets no acknowledge and changes no memory. After the write, the counter points at the next address.
- R10: The low SEL_BITS bits of the select byte (bits SEL_BITS..1) become the upper address bits, so the same byte address in different blocks holds different bytes.
- R11: The slave starts pulling SDA low only while SCL is low.
- R12: After the master answers a read byte with no acknowledge, the slave releases SDA for the rest of the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| por_hold | input | 1 | Power-on hold: high keeps the slave silent and idle |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| wr_lock | input | 1 | High blocks data writes (tie low when unused) |
| sda_low | output | 1 | High pulls the data line low |
| busy | output | 1 | High while the internal programming window runs |

## Verification
The bench builds the block with ADDR_W=8 and SEL_BITS=1, a 512-byte array. With this size the top-address wrap and the block-bit decode are reached in only a few commands. WR_CYCLES is set to 400, so the programming window outlasts a whole select byte sent during it, and its length can be counted exactly. SYNC_STAGES stays at 2, and the bus quarter-bit lasts 6 clocks. This gives margin over the three-clock delay between a line edge and the slave's reaction to it.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

  // protocol phase of the slave
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // waiting for START
    ST_DEV  = 3'd1,  // receiving select byte
    ST_ADR  = 3'd2,  // receiving byte address
    ST_WR   = 3'd3,  // receiving data byte
    ST_RD   = 3'd4,  // sending data bytes
    ST_WAIT = 3'd5   // silent until START or STOP
  } twi_state_e;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic lock_i,
  output logic scl_o,
  output logic sda_o,
  output logic lock_o,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_sh, sda_sh, lock_sh;
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh  <= '1;
      sda_sh  <= '1;
      lock_sh <= '0;
      scl_p   <= 1'b1;
      sda_p   <= 1'b1;
    end else begin
      scl_sh  <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh  <= {sda_sh[STAGES-2:0], sda_i};
      lock_sh <= {lock_sh[STAGES-2:0], lock_i};
      scl_p   <= scl_sh[STAGES-1];
      sda_p   <= sda_sh[STAGES-1];
    end
  end

  assign scl_o     = scl_sh[STAGES-1];
  assign sda_o     = sda_sh[STAGES-1];
  assign lock_o    = lock_sh[STAGES-1];
  assign scl_rise  = scl_o & ~scl_p;
  assign scl_fall  = ~scl_o & scl_p;
  // data edges qualified by a clock that stayed high
  assign start_det = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_det  = scl_o & scl_p & ~sda_p & sda_o;

endmodule

// File: rtl/twi_busy_timer.sv
module twi_busy_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic clr,
  input  logic start_i,
  output logic busy_o
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr)               cnt <= '0;
    else if (start_i)      cnt <= CW'(CYCLES);
    else if (cnt != '0)    cnt <= cnt - CW'(1);
  end

  assign busy_o = (cnt != '0);

endmodule

// File: rtl/twi_byte_ram.sv
module twi_byte_ram #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single write port, registered read port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_mem_pkg::*;
#(
  parameter int ADDR_W      = 8,    // byte address bits, at most 8
  parameter int SEL_BITS    = 1,    // block bits taken from the select byte, 1..3
  parameter int WR_CYCLES   = 1000, // programming window in clocks
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic por_hold,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wr_lock,
  output logic sda_low,
  output logic busy
);

  localparam int AW = ADDR_W + SEL_BITS;

  logic scl_s, sda_s, lock_s, scl_rise, scl_fall, start_det, stop_det;
  logic clr, mem_we, dev_ok;
  logic [7:0] rdata, rx, tx;
  logic [3:0] bit_cnt;
  logic ack_ph, oe, mack, wr_pend;
  logic [AW-1:0] addr, wr_addr;
  logic [7:0] wr_data;
  twi_state_e state, nxt;

  assign clr = rst | por_hold;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .lock_i(wr_lock),
    .scl_o(scl_s), .sda_o(sda_s), .lock_o(lock_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_busy_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .clr(clr), .start_i(mem_we), .busy_o(busy)
  );

  twi_byte_ram #(.AW(AW), .DW(8)) u_ram (
    .clk(clk), .we(mem_we), .waddr(wr_addr), .wdata(wr_data),
    .raddr(addr), .rdata(rdata)
  );

  // commit the held byte on the STOP that ends an accepted write
  assign mem_we = stop_det & wr_pend & ~busy & ~por_hold;

  // prefix, then zeros above the block bits
  assign dev_ok = (rx[7:4] == DEV_PREFIX) && ((rx[3:1] >> SEL_BITS) == 3'd0);

  always_ff @(posedge clk) begin
    if (clr) begin
      state   <= ST_IDLE;
      nxt     <= ST_IDLE;
      bit_cnt <= '0;
      ack_ph  <= 1'b0;
      oe      <= 1'b0;
      rx      <= '0;
      tx      <= '0;
      mack    <= 1'b0;
      wr_pend <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      if (rst) addr <= '0;
    end else if (busy) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      ack_ph  <= 1'b0;
      oe      <= 1'b0;
      wr_pend <= 1'b0;
    end else if (start_det) begin
      state   <= ST_DEV;
      bit_cnt <= '0;
      ack_ph  <= 1'b0;
      oe      <= 1'b0;
      wr_pend <= 1'b0;
    end else if (stop_det) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      ack_ph  <= 1'b0;
      oe      <= 1'b0;
      wr_pend <= 1'b0;
    end else begin
      unique case (state)
        ST_DEV, ST_ADR, ST_WR: begin
          if (!ack_ph) begin
            if (scl_rise && bit_cnt < 4'd8) begin
              rx      <= {rx[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              ack_ph <= 1'b1;
              if (state == ST_DEV) begin
                if (dev_ok) begin
                  oe                   <= 1'b1;
                  addr[AW-1:ADDR_W]    <= rx[SEL_BITS:1];
                  nxt                  <= rx[0] ? ST_RD : ST_ADR;
                end else begin
                  state   <= ST_IDLE;
                  ack_ph  <= 1'b0;
                  bit_cnt <= '0;
                end
              end else if (state == ST_ADR) begin
                oe               <= 1'b1;
                addr[ADDR_W-1:0] <= rx[ADDR_W-1:0];
                nxt              <= ST_WR;
              end else begin
                nxt <= ST_WAIT;
                if (!lock_s) begin
                  oe      <= 1'b1;
                  wr_addr <= addr;
                  wr_data <= rx;
                  wr_pend <= 1'b1;
                  addr    <= addr + AW'(1);
                end
              end
            end
          end else if (scl_fall) begin
            ack_ph  <= 1'b0;
            bit_cnt <= '0;
            state   <= nxt;
            if (nxt == ST_RD) begin
              oe   <= ~rdata[7];
              tx   <= {rdata[6:0], 1'b0};
              addr <= addr + AW'(1);
            end else begin
              oe <= 1'b0;
            end
          end
        end
        ST_RD: begin
          if (!ack_ph) begin
            if (scl_rise && bit_cnt < 4'd8) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              oe     <= 1'b0;
              ack_ph <= 1'b1;
            end else if (scl_fall && bit_cnt != 4'd0) begin
              oe <= ~tx[7];
              tx <= {tx[6:0], 1'b0};
            end
          end else if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            ack_ph  <= 1'b0;
            bit_cnt <= '0;
            if (mack) begin
              oe   <= ~rdata[7];
              tx   <= {rdata[6:0], 1'b0};
              addr <= addr + AW'(1);
            end else begin
              oe    <= 1'b0;
              state <= ST_WAIT;
            end
          end
        end
        default: begin
          oe <= 1'b0;
        end
      endcase
    end
  end

  assign sda_low = oe;

  AST_POR_QUIET: assert property (@(posedge clk) disable iff (rst)
    por_hold |=> !sda_low) else $error("por hold drove sda"); // R1
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_low) else $error("sda driven while busy"); // R6
  AST_BUSY_AFTER_WE: assert property (@(posedge clk) disable iff (rst || por_hold)
    mem_we |=> busy) else $error("commit without busy window"); // R6
  AST_DRIVE_ON_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_low) |-> !$past(scl_s)) else $error("drive began with scl high"); // R11

endmodule

// File: tb/tb_twi_mem_slave.sv
module tb_twi_mem_slave;

  localparam int CLK_PERIOD = 10;
  localparam int Q   = 6;
  localparam int WRC = 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic por_hold = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wr_lock = 1'b0;
  logic sda_low, busy, sda_line;
  logic done = 1'b0;
  int checks = 0;
  int errors = 0;
  int run = 0;
  int last_run = 0;

  assign sda_line = sda_m & ~sda_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  twi_mem_slave #(.ADDR_W(8), .SEL_BITS(1), .WR_CYCLES(WRC), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .por_hold(por_hold), .scl_i(scl_m), .sda_i(sda_line),
    .wr_lock(wr_lock), .sda_low(sda_low), .busy(busy)
  );

  always @(negedge clk) begin
    if (rst) run = 0;
    else if (busy) run = run + 1;
    else if (run != 0) begin last_run = run; run = 0; end
  end

  // {lock, blk, addr, data, expected data ack, expected read}
  localparam logic [26:0] VEC [7] = '{
    {1'b0, 1'b0, 8'h10, 8'h5A, 1'b1, 8'h5A},
    {1'b0, 1'b1, 8'h10, 8'hC3, 1'b1, 8'hC3},
    {1'b1, 1'b0, 8'h10, 8'h99, 1'b0, 8'h5A},
    {1'b0, 1'b0, 8'hFF, 8'h77, 1'b1, 8'h77},
    {1'b0, 1'b1, 8'hFF, 8'hE1, 1'b1, 8'hE1},
    {1'b0, 1'b0, 8'h00, 8'h3C, 1'b1, 8'h3C},
    {1'b1, 1'b1, 8'h10, 8'h00, 1'b0, 8'hC3}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] sel(input logic blk, input logic rd);
    return {4'b1010, 2'b00, blk, rd};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    acked = (sda_line == 1'b0);
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_byte(output logic [7:0] d, input logic give_ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      d[i] = sda_line;
      tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = ~give_ack; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic wait_ready();
    for (int k = 0; k < 4*WRC && busy; k++) tick(1);
  endtask

  task automatic write_cmd(input logic blk, input logic [7:0] a, input logic [7:0] d,
                           output logic k1, output logic k2, output logic k3);
    bus_start();
    put_byte(sel(blk, 1'b0), k1);
    put_byte(a, k2);
    put_byte(d, k3);
    bus_stop();
  endtask

  task automatic read_random(input logic blk, input logic [7:0] a, input logic more,
                             output logic [7:0] d);
    logic k;
    bus_start();
    put_byte(sel(blk, 1'b0), k);
    chk("R7 address-set select ack", k, 1);
    put_byte(a, k);
    chk("R7 address byte ack", k, 1);
    bus_start();
    put_byte(sel(blk, 1'b1), k);
    chk("R2 read select ack", k, 1);
    get_byte(d, more);
    if (!more) bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic k1, k2, k3;
    logic [7:0] d;
    tick(5);
    rst = 1'b0;
    tick(2);
    // R1: reset state
    chk("R1 sda_low after reset", sda_low, 0);
    chk("R1 busy after reset", busy, 0);

    // R1: power-on hold silences a matching select
    por_hold = 1'b1;
    tick(2);
    bus_start();
    put_byte(sel(1'b0, 1'b0), k1);
    chk("R1 no ack under por_hold", k1, 0);
    bus_stop();
    por_hold = 1'b0;
    tick(4);

    // vector table: write then random read
    for (int i = 0; i < 7; i++) begin
      wr_lock = VEC[i][26];
      tick(4);
      write_cmd(VEC[i][25], VEC[i][24:17], VEC[i][16:9], k1, k2, k3);
      chk("R2 write select ack", k1, 1);
      chk("R4 R5 address ack", k2, 1);
      chk("R4 R5 data ack", k3, int'(VEC[i][8]));
      if (VEC[i][8]) begin
        chk("R6 busy after stop", busy, 1);
        wait_ready();
        tick(2);
        chk("R6 busy window length", last_run, WRC);
      end else begin
        chk("R5 no busy when locked", busy, 0);
      end
      wr_lock = 1'b0;
      tick(4);
      read_random(VEC[i][25], VEC[i][24:17], 1'b0, d);
      chk("R4 R5 R7 R10 readback", d, int'(VEC[i][7:0]));
      tick(4);
    end

    // R3: wrong prefix, then wrong zero bits
    bus_start();
    put_byte(8'hB0, k1);
    chk("R3 wrong prefix nack", k1, 0);
    put_byte(8'h10, k2);
    chk("R3 later byte ignored", k2, 0);
    bus_stop();
    bus_start();
    put_byte(8'hA8, k1);
    chk("R3 nonzero upper select bits nack", k1, 0);
    bus_stop();
    tick(4);

    // R8: sequential read across top of array, R12 release after nack
    read_random(1'b1, 8'hFF, 1'b1, d);
    chk("R8 top byte", d, 8'hE1);
    get_byte(d, 1'b0);
    chk("R8 wrap to address 0", d, 8'h3C);
    get_byte(d, 1'b0);
    chk("R12 released after master nack", d, 8'hFF);
    bus_stop();
    tick(4);

    // R8: current-address read, block bits from the select
    read_random(1'b0, 8'hFF, 1'b0, d);
    chk("R8 random read 0x0FF", d, 8'h77);
    bus_start();
    put_byte(sel(1'b0, 1'b1), k1);
    chk("R8 current read select ack", k1, 1);
    get_byte(d, 1'b0);
    bus_stop();
    chk("R8 current read from counter", d, 8'h3C);
    tick(4);

    // R9: second data byte rejected, counter points past the write
    bus_start();
    put_byte(sel(1'b0, 1'b0), k1);
    put_byte(8'hFE, k2);
    put_byte(8'h11, k3);
    chk("R9 first data ack", k3, 1);
    put_byte(8'h22, k3);
    chk("R9 second data nack", k3, 0);
    bus_stop();
    wait_ready();
    tick(4);
    bus_start();
    put_byte(sel(1'b0, 1'b1), k1);
    get_byte(d, 1'b0);
    bus_stop();
    chk("R9 next address untouched", d, 8'h77);
    tick(4);
    read_random(1'b0, 8'hFE, 1'b0, d);
    chk("R9 R4 first data stored", d, 8'h11);
    tick(4);

    // R6: bus ignored during programming window
    write_cmd(1'b0, 8'h30, 8'h44, k1, k2, k3);
    chk("R6 busy raised", busy, 1);
    bus_start();
    put_byte(sel(1'b0, 1'b1), k1);
    chk("R6 select ignored while busy", k1, 0);
    bus_stop();
    wait_ready();
    tick(4);
    read_random(1'b0, 8'h30, 1'b0, d);
    chk("R6 R4 data after window", d, 8'h44);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule